// File: doc/BRIEF.md
# Interrupt Level Evaluator

This block decides which interrupt level a processor core should take next. Each clock it looks at every interrupt source: the machine-check, corrected-read and power-fail pins, four external request lines with their own mask bits, a fifteen-bit software request word, and a four-bit pair of asynchronous-trap request and enable words. From these it forms a single priority level. The asynchronous-trap requests are gated by a mask that depends on the current privilege mode. The level is then compared with the current priority level of the core, and any level that does not exceed it is reduced to zero. Two flag bits, serial-line attention and halt, are added after that comparison, so the priority level can never hide them. While the core runs privileged firmware, the whole result is held at zero.

A second output gives the interrupt identifier. It uses the same evaluation, but as if the priority level were zero and firmware mode were off. Firmware reads it to learn what is pending. Both outputs are registered and follow the inputs of the previous clock. Every input is a plain level signal sampled each clock. There is no handshake, because the block only reports levels and never takes or acknowledges an interrupt.

Top module: `intlv_eval`

## Requirements
- R1: While `rst_ni` is low, `code_o` and `id_o` are both zero.
- R2: Pending sources are ranked from highest to lowest: machine check (level 31), enabled corrected-read (level 26), power fail (level 30), external line 3, 2, 1, 0 (levels 23, 22, 21, 20). The highest-ranked active source gives the level, even when a lower-ranked source has a numerically higher level.
- R3: An external line whose `irq_mask_i` bit is 1 is ignored. A corrected-read request is ignored while `crd_en_i` is 0.
- R4: When none of the R2 sources is active, the level is i+1, where i is the highest set bit of `sw_req_i`. If no bit is set, the level is 0.
- R5: An asynchronous-trap bit b is qualified when its request bit and enable bit are both 1 and b is not greater than the mode value. The mode encoding is 0 kernel, 1 executive, 2 supervisor, 3 user.
- R6: If any trap bit is qualified and the level formed by R2 to R4 is below 2, the level becomes 2. Otherwise the level is unchanged.
- R7: In `code_o[4:0]`, a level less than or equal to `ipl_i` is replaced by 0.
- R8: While `fw_mode_i` is 1, all of `code_o` is 0, including the flag bits.
- R9: `code_o[5]` is 1 when `sli_req_i` and `sli_en_i` are both 1, whatever the level and `ipl_i`.
- R10: `code_o[6]` is 1 when `halt_req_i` is 1, whatever the level and `ipl_i`.
- R11: `id_o` is the level from R2 to R6, with neither the `ipl_i` comparison nor the firmware suppression applied, and without flag bits.
- R12: Both outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mchk_i | input | 1 | Machine-check request |
| crd_i | input | 1 | Corrected-read-data request |
| crd_en_i | input | 1 | Enable for the corrected-read request |
| pwr_fail_i | input | 1 | Power-fail request |
| irq_i | input | 4 | External interrupt lines |
| irq_mask_i | input | 4 | Per-line mask, 1 suppresses the line |
| sw_req_i | input | 15 | Software request word, bit i means level i+1 |
| ast_req_i | input | 4 | Asynchronous-trap request bits |
| ast_en_i | input | 4 | Asynchronous-trap enable bits |
| mode_i | input | 2 | Current privilege mode |
| ipl_i | input | 5 | Current interrupt priority level |
| fw_mode_i | input | 1 | Core runs privileged firmware |
| sli_req_i | input | 1 | Serial-line attention request |
| sli_en_i | input | 1 | Enable for the serial-line flag |
| halt_req_i | input | 1 | Halt request |
| code_o | output | 7 | [4:0] level above IPL, [5] serial flag, [6] halt flag |
| id_o | output | 5 | Interrupt identifier level |

## Verification
The trap promotion and the priority-level comparison can act on the same level in one cycle. For example, a software level 1 with a qualified trap becomes 2 in `id_o`, but it must disappear from `code_o` when `ipl_i` is 2. The halt and serial flags can also be set in the same cycle that the comparison reduces the level to zero. Directed vectors create each of these overlaps, and long random runs with `ipl_i` spread across its whole range create them by chance. A behavioural model in the bench, which knows nothing of the RTL structure, judges every cycle on both outputs.

// File: rtl/intlv_pkg.sv
package intlv_pkg;
  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_EXEC = 2'd1,
    MODE_SUPV = 2'd2,
    MODE_USER = 2'd3
  } cpu_mode_e;

  localparam int unsigned FLAG_BITS = 2;
endpackage

// File: rtl/intlv_hw_chain.sv
module intlv_hw_chain #(
  parameter int unsigned LVL_W    = 5,
  parameter int unsigned HW_LINES = 4,
  parameter int unsigned HW_BASE  = 20,
  parameter int unsigned MCHK_LVL = 31,
  parameter int unsigned CRD_LVL  = 26,
  parameter int unsigned PWR_LVL  = 30
) (
  input  logic                mchk_i,
  input  logic                crd_i,
  input  logic                crd_en_i,
  input  logic                pwr_fail_i,
  input  logic [HW_LINES-1:0] irq_i,
  input  logic [HW_LINES-1:0] irq_mask_i,
  output logic [LVL_W-1:0]    lvl_o,
  output logic                hit_o
);
  logic [HW_LINES-1:0] live;
  logic                crd_live;

  for (genvar g = 0; g < HW_LINES; g++) begin : g_line
    assign live[g] = irq_i[g] & ~irq_mask_i[g];
  end

  assign crd_live = crd_i & crd_en_i;

  // later assignments take precedence: lowest rank first
  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < HW_LINES; i++) begin
      if (live[i]) lvl_o = LVL_W'(HW_BASE + i);
    end
    if (pwr_fail_i) lvl_o = LVL_W'(PWR_LVL);
    if (crd_live)   lvl_o = LVL_W'(CRD_LVL);
    if (mchk_i)     lvl_o = LVL_W'(MCHK_LVL);
  end

  assign hit_o = mchk_i | crd_live | pwr_fail_i | (|live);
endmodule

// File: rtl/intlv_sw_enc.sv
module intlv_sw_enc #(
  parameter int unsigned LVL_W   = 5,
  parameter int unsigned SW_BITS = 15
) (
  input  logic [SW_BITS-1:0] sw_req_i,
  output logic [LVL_W-1:0]   lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < SW_BITS; i++) begin
      if (sw_req_i[i]) lvl_o = LVL_W'(i + 1);
    end
  end
endmodule

// File: rtl/intlv_ast_qual.sv
module intlv_ast_qual
  import intlv_pkg::*;
#(
  parameter int unsigned AST_BITS = 4
) (
  input  logic [AST_BITS-1:0] ast_req_i,
  input  logic [AST_BITS-1:0] ast_en_i,
  input  cpu_mode_e           mode_i,
  output logic                any_o
);
  logic [AST_BITS-1:0] ok;

  // bit b is reachable from mode m when b <= m
  for (genvar b = 0; b < AST_BITS; b++) begin : g_bit
    assign ok[b] = ast_req_i[b] & ast_en_i[b] & (b <= int'(mode_i));
  end

  assign any_o = |ok;
endmodule

// File: rtl/intlv_eval.sv
module intlv_eval
  import intlv_pkg::*;
#(
  parameter int unsigned LVL_W    = 5,
  parameter int unsigned HW_LINES = 4,
  parameter int unsigned SW_BITS  = 15,
  parameter int unsigned AST_BITS = 4,
  parameter int unsigned HW_BASE  = 20,
  parameter int unsigned MCHK_LVL = 31,
  parameter int unsigned CRD_LVL  = 26,
  parameter int unsigned PWR_LVL  = 30,
  parameter int unsigned AST_LVL  = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mchk_i,
  input  logic                  crd_i,
  input  logic                  crd_en_i,
  input  logic                  pwr_fail_i,
  input  logic [HW_LINES-1:0]   irq_i,
  input  logic [HW_LINES-1:0]   irq_mask_i,
  input  logic [SW_BITS-1:0]    sw_req_i,
  input  logic [AST_BITS-1:0]   ast_req_i,
  input  logic [AST_BITS-1:0]   ast_en_i,
  input  logic [1:0]            mode_i,
  input  logic [LVL_W-1:0]      ipl_i,
  input  logic                  fw_mode_i,
  input  logic                  sli_req_i,
  input  logic                  sli_en_i,
  input  logic                  halt_req_i,
  output logic [LVL_W+1:0]      code_o,
  output logic [LVL_W-1:0]      id_o
);
  localparam int unsigned CODE_W = LVL_W + FLAG_BITS;
  localparam logic [LVL_W-1:0] AST_L = LVL_W'(AST_LVL);

  logic [LVL_W-1:0]  hw_lvl, sw_lvl, base_lvl, prom_lvl, real_lvl;
  logic              hw_hit, ast_any;
  logic [CODE_W-1:0] code_d, code_q;
  logic [LVL_W-1:0]  id_q;

  intlv_hw_chain #(
    .LVL_W(LVL_W), .HW_LINES(HW_LINES), .HW_BASE(HW_BASE),
    .MCHK_LVL(MCHK_LVL), .CRD_LVL(CRD_LVL), .PWR_LVL(PWR_LVL)
  ) u_hw (
    .mchk_i(mchk_i), .crd_i(crd_i), .crd_en_i(crd_en_i),
    .pwr_fail_i(pwr_fail_i), .irq_i(irq_i), .irq_mask_i(irq_mask_i),
    .lvl_o(hw_lvl), .hit_o(hw_hit)
  );

  intlv_sw_enc #(.LVL_W(LVL_W), .SW_BITS(SW_BITS)) u_sw (
    .sw_req_i(sw_req_i), .lvl_o(sw_lvl)
  );

  intlv_ast_qual #(.AST_BITS(AST_BITS)) u_ast (
    .ast_req_i(ast_req_i), .ast_en_i(ast_en_i),
    .mode_i(cpu_mode_e'(mode_i)), .any_o(ast_any)
  );

  always_comb begin
    base_lvl = hw_hit ? hw_lvl : sw_lvl;
    prom_lvl = (ast_any && (base_lvl < AST_L)) ? AST_L : base_lvl;
    real_lvl = (prom_lvl > ipl_i) ? prom_lvl : '0;
    if (fw_mode_i) code_d = '0;
    else           code_d = {halt_req_i, sli_req_i & sli_en_i, real_lvl};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      id_q   <= '0;
    end else begin
      code_q <= code_d;
      id_q   <= prom_lvl;
    end
  end

  assign code_o = code_q;
  assign id_o   = id_q;
endmodule

// File: rtl/intlv_chk.sv
module intlv_chk #(
  parameter int unsigned LVL_W    = 5,
  parameter int unsigned MCHK_LVL = 31
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mchk_i,
  input logic             fw_mode_i,
  input logic [LVL_W-1:0] ipl_i,
  input logic             sli_req_i,
  input logic             sli_en_i,
  input logic             halt_req_i,
  input logic [LVL_W+1:0] code_o,
  input logic [LVL_W-1:0] id_o
);
  AST_FW_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw_mode_i |=> (code_o == '0)); // R8

  AST_MCHK_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mchk_i |=> (id_o == LVL_W'(MCHK_LVL))); // R2

  AST_ABOVE_IPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o[LVL_W-1:0] != '0) |-> (code_o[LVL_W-1:0] > $past(ipl_i))); // R7

  AST_HALT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_req_i && !fw_mode_i) |=> code_o[LVL_W+1]); // R10

  AST_SLI_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sli_req_i && sli_en_i && !fw_mode_i) |=> code_o[LVL_W]); // R9

  AST_ID_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o[LVL_W-1:0] != '0) |-> (code_o[LVL_W-1:0] == id_o)); // R11
endmodule

bind intlv_eval intlv_chk #(.LVL_W(LVL_W), .MCHK_LVL(MCHK_LVL)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mchk_i(mchk_i), .fw_mode_i(fw_mode_i),
  .ipl_i(ipl_i), .sli_req_i(sli_req_i), .sli_en_i(sli_en_i),
  .halt_req_i(halt_req_i), .code_o(code_o), .id_o(id_o)
);

// File: tb/intlv_eval_test.sv
module intlv_eval_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        mchk, crd, crd_en, pwr;
  logic [3:0]  irq, irq_mask;
  logic [14:0] sw;
  logic [3:0]  ast_req, ast_en;
  logic [1:0]  mode;
  logic [4:0]  ipl;
  logic        fw, sli_req, sli_en, halt;
  logic [6:0]  code;
  logic [4:0]  id;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intlv_eval uut (
    .clk_i(clk), .rst_ni(rst_ni), .mchk_i(mchk), .crd_i(crd),
    .crd_en_i(crd_en), .pwr_fail_i(pwr), .irq_i(irq), .irq_mask_i(irq_mask),
    .sw_req_i(sw), .ast_req_i(ast_req), .ast_en_i(ast_en), .mode_i(mode),
    .ipl_i(ipl), .fw_mode_i(fw), .sli_req_i(sli_req), .sli_en_i(sli_en),
    .halt_req_i(halt), .code_o(code), .id_o(id)
  );

  // behavioural model of the level before IPL and firmware
  function automatic int model_level();
    int lvl = 0;
    bit found = 0;
    int amask;
    if (mchk) lvl = 31;
    else if (crd && crd_en) lvl = 26;
    else if (pwr) lvl = 30;
    else begin
      for (int k = 3; k >= 0; k--)
        if (!found && irq[k] && !irq_mask[k]) begin lvl = 20 + k; found = 1; end
      if (!found)
        for (int k = 14; k >= 0; k--)
          if (!found && sw[k]) begin lvl = k + 1; found = 1; end
    end
    amask = (1 << (int'(mode) + 1)) - 1;
    if (lvl < 2 && ((int'(ast_req) & int'(ast_en) & amask) != 0)) lvl = 2;
    return lvl;
  endfunction

  function automatic logic [6:0] model_code();
    int lvl = model_level();
    int r = (lvl <= int'(ipl)) ? 0 : lvl;
    if (fw) return 7'd0;
    return {halt, sli_req & sli_en, 5'(r)};
  endfunction

  task automatic clear_in();
    mchk = 0; crd = 0; crd_en = 0; pwr = 0; irq = 0; irq_mask = 0;
    sw = 0; ast_req = 0; ast_en = 0; mode = 0; ipl = 0; fw = 0;
    sli_req = 0; sli_en = 0; halt = 0;
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // inputs are set at a falling edge; sample one clock later (R12)
  task automatic step(string tag);
    logic [6:0] ec;
    logic [4:0] ei;
    ec = model_code();
    ei = 5'(model_level());
    @(posedge clk);
    @(negedge clk);
    check({tag, " code"}, int'(code), int'(ec));
    check({tag, " id"},   int'(id),   int'(ei));
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_ni = 0;
    clear_in();
    mchk = 1; halt = 1;
    repeat (3) @(negedge clk);
    check("R1 reset code", int'(code), 0);
    check("R1 reset id", int'(id), 0);
    rst_ni = 1;
    clear_in();
    step("R1 idle");

    // R2 priority order
    clear_in(); mchk = 1; pwr = 1; irq = 4'b1000; step("R2 mchk wins");
    clear_in(); crd = 1; crd_en = 1; pwr = 1; step("R2 crd over pwr");
    clear_in(); pwr = 1; irq = 4'b1111; step("R2 pwr over irq");
    clear_in(); irq = 4'b1001; step("R2 irq3 over irq0");
    clear_in(); irq = 4'b0010; sw = 15'h7fff; step("R2 irq1 over sw");

    // R3 masks and enable
    clear_in(); irq = 4'b1100; irq_mask = 4'b1000; step("R3 irq3 masked");
    clear_in(); crd = 1; irq = 4'b0001; step("R3 crd disabled");
    clear_in(); irq = 4'b1111; irq_mask = 4'b1111; sw = 15'h0010; step("R3 all masked");

    // R4 software levels
    clear_in(); sw = 15'h0011; step("R4 sw mixed");
    clear_in(); sw = 15'h4000; step("R4 sw top");
    clear_in(); sw = 15'h0001; step("R4 sw bottom");

    // R5 trap mode qualification
    clear_in(); mode = 0; ast_req = 4'b0010; ast_en = 4'b0010; step("R5 kern blocks bit1");
    clear_in(); mode = 1; ast_req = 4'b0010; ast_en = 4'b0010; step("R5 exec passes bit1");
    clear_in(); mode = 3; ast_req = 4'b1000; ast_en = 4'b0111; step("R5 enable off");
    clear_in(); mode = 3; ast_req = 4'b1000; ast_en = 4'b1000; step("R5 user bit3");

    // R6 promotion only below trap level
    clear_in(); sw = 15'h0004; ast_req = 4'h1; ast_en = 4'h1; step("R6 no demote");
    clear_in(); sw = 15'h0001; ast_req = 4'h1; ast_en = 4'h1; step("R6 promote");

    // R7 IPL compare, with promotion in the same cycle
    clear_in(); irq = 4'b0100; ipl = 22; step("R7 equal ipl");
    clear_in(); irq = 4'b0100; ipl = 21; step("R7 below ipl");
    clear_in(); sw = 15'h0001; ast_req = 4'h1; ast_en = 4'h1; ipl = 2; step("R7 promoted masked");

    // R8 firmware mode
    clear_in(); fw = 1; mchk = 1; halt = 1; sli_req = 1; sli_en = 1; step("R8 fw silent");

    // R9 serial flag
    clear_in(); sli_req = 1; sli_en = 1; ipl = 31; step("R9 sli through ipl");
    clear_in(); sli_req = 1; step("R9 sli disabled");

    // R10 halt flag
    clear_in(); halt = 1; pwr = 1; ipl = 31; step("R10 halt through ipl");

    // R11 identifier ignores IPL and fw
    clear_in(); fw = 1; sw = 15'h0100; ipl = 31; step("R11 id unmasked");

    // R12 random cycle-by-cycle comparison
    for (int n = 0; n < 600; n++) begin
      mchk     = ($urandom % 16) == 0;
      crd      = ($urandom % 6) == 0;
      crd_en   = $urandom % 2;
      pwr      = ($urandom % 10) == 0;
      irq      = 4'($urandom) & 4'($urandom);
      irq_mask = 4'($urandom);
      sw       = 15'($urandom) & 15'($urandom) & 15'($urandom);
      ast_req  = 4'($urandom);
      ast_en   = 4'($urandom);
      mode     = 2'($urandom);
      ipl      = 5'($urandom);
      fw       = ($urandom % 8) == 0;
      sli_req  = $urandom % 2;
      sli_en   = $urandom % 2;
      halt     = ($urandom % 5) == 0;
      step("R12 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule